// File: doc/BRIEF.md
# Predicted Address Probe Queue

The block sits between a front-end load-address predictor and the data cache. Each cycle it can take in up to two predicted load addresses, listed in program order. Each address comes with an access size, a hint naming the cache way that should hold the line, and a destination tag. The queue sends these addresses to the cache as speculative probes, but only in cycles where the load-store execution lane has nothing of its own to do. A probe reads only the hinted way.

The cache answers a probe exactly one cycle after it is issued. A hit passes the returned data and the destination tag on to the value prediction engine. A miss can raise a prefetch request for the same address.

Predictions become stale quickly. An entry that waits too long is thrown away without a probe, and each such loss is counted. When the queue holds nothing and the lane is free, a new prediction goes straight to the probe port without being stored.

Top module: `pred_probe_queue`

## Requirements
- R1: While reset is held and in the first cycle after it, no probe, value or prefetch output is valid, and the drop count reads 0.
- R2: Stored predictions are probed strictly in arrival order. When both input slots are valid in the same cycle, slot 0 counts as older than slot 1.
- R3: A probe is issued only in a cycle where `lane_idle` is 1. When the lane is busy, entries are held and are not lost.
- R4: The bypass path applies when the queue is empty and `lane_idle` is 1. The first valid input slot (slot 0 before slot 1) is probed combinationally in that same cycle, and a remaining valid slot is stored.
- R5: An entry written at the clock edge that ends cycle t can be probed in cycles t+1 to t+4. Once it is head in cycle t+5 or later, it is removed without a probe and `drop_count` rises by 1 in the following cycle. Only one entry is removed per cycle, and an expiry cycle issues no probe.
- R6: The queue holds 32 entries. The free space for a cycle is the space left at the start of that cycle. Valid inputs beyond that space are discarded, with slot 1 discarded before slot 0. Discarded inputs are never probed and never counted as drops.
- R7: The response arrives one cycle after its probe. When `rsp_valid` and `rsp_hit` are both 1, `vpe_valid` is 1 in that same cycle, with the probe's tag on `vpe_tag` and `rsp_data` on `vpe_data`.
- R8: When `rsp_valid` is 1 and `rsp_hit` is 0 for an issued probe, `pf_valid` is 1 in that same cycle and `pf_addr` carries the probed address. The prefetch parameter defaults to on. `vpe_valid` and `pf_valid` are never 1 together.
- R9: A response that arrives when no probe was issued in the previous cycle raises neither `vpe_valid` nor `pf_valid`.
- R10: The 2-bit size and the 2-bit way hint reach `probe_size` and `probe_way` unchanged, alongside the same entry's address and tag.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_v0 | input | 1 | Slot 0 prediction valid (older) |
| in_addr0 | input | 32 | Slot 0 predicted address |
| in_size0 | input | 2 | Slot 0 access size code |
| in_way0 | input | 2 | Slot 0 way hint |
| in_tag0 | input | 6 | Slot 0 destination tag |
| in_v1 | input | 1 | Slot 1 prediction valid (younger) |
| in_addr1 | input | 32 | Slot 1 predicted address |
| in_size1 | input | 2 | Slot 1 access size code |
| in_way1 | input | 2 | Slot 1 way hint |
| in_tag1 | input | 6 | Slot 1 destination tag |
| lane_idle | input | 1 | Load-store lane has a bubble this cycle |
| probe_valid | output | 1 | Cache probe request |
| probe_addr | output | 32 | Probe address |
| probe_size | output | 2 | Probe size code |
| probe_way | output | 2 | Way to read |
| probe_tag | output | 6 | Destination tag of the probe |
| rsp_valid | input | 1 | Cache response valid |
| rsp_hit | input | 1 | Response hit indication |
| rsp_data | input | 64 | Response data |
| vpe_valid | output | 1 | Value forwarded to the prediction engine |
| vpe_tag | output | 6 | Destination tag of the forwarded value |
| vpe_data | output | 64 | Forwarded value |
| pf_valid | output | 1 | Prefetch request |
| pf_addr | output | 32 | Prefetch address |
| drop_count | output | 16 | Count of expired entries, wrapping |

## Verification
In a single cycle, an expired head can compete with a free lane and new arrivals. The expiry has to win: no probe and no bypass are issued, while the new predictions are still stored.

The bench sets this up in two ways. It ages entries behind a busy lane and then frees the lane exactly as the head crosses its fourth cycle. It also runs long random stretches that mix lane availability, dual arrivals and stray responses.

Every cycle, a behavioural queue model predicts the probe port, the response routing and the drop count, and each of these is compared with the design.

// File: rtl/ppq_pkg.sv
package ppq_pkg;
  // What the head of the queue does in a given cycle
  typedef enum logic [1:0] {
    ACT_NONE   = 2'd0,
    ACT_HEAD   = 2'd1,
    ACT_BYPASS = 2'd2,
    ACT_EXPIRE = 2'd3
  } ppq_act_e;
endpackage

// File: rtl/ppq_store.sv
// Circular entry store with two ordered write ports and a per-slot age.
// DEPTH must be a power of two so that the pointers wrap naturally.
module ppq_store #(
  parameter int ENT_W     = 42,
  parameter int DEPTH     = 32,
  parameter int AGE_LIMIT = 4,
  localparam int PTR_W    = $clog2(DEPTH),
  localparam int CNT_W    = $clog2(DEPTH + 1),
  localparam int AGE_W    = $clog2(AGE_LIMIT + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             we0,
  input  logic [ENT_W-1:0] wd0,
  input  logic             we1,
  input  logic [ENT_W-1:0] wd1,
  input  logic             pop,
  output logic [ENT_W-1:0] head_d,
  output logic [AGE_W-1:0] head_age,
  output logic [CNT_W-1:0] count
);

  logic [ENT_W-1:0] mem_q [DEPTH];
  logic [AGE_W-1:0] age_q [DEPTH];
  logic [AGE_W-1:0] age_d [DEPTH];
  logic [PTR_W-1:0] wptr_q, wptr_d, wptr1, rptr_q, rptr_d;
  logic [CNT_W-1:0] cnt_q, cnt_d;

  assign wptr1 = wptr_q + PTR_W'(1);

  // Next-state: pointers and occupancy
  always_comb begin
    wptr_d = wptr_q + PTR_W'(we0) + PTR_W'(we1);
    rptr_d = rptr_q + PTR_W'(pop);
    cnt_d  = cnt_q + CNT_W'(we0) + CNT_W'(we1) - CNT_W'(pop);
  end

  // Next-state: ages saturate at the limit, freshly written slots start at 0
  always_comb begin
    for (int i = 0; i < DEPTH; i++) begin
      age_d[i] = age_q[i];
      if (age_q[i] != AGE_W'(AGE_LIMIT)) age_d[i] = age_q[i] + AGE_W'(1);
      if (we0 && (wptr_q == PTR_W'(i))) age_d[i] = '0;
      if (we1 && (wptr1 == PTR_W'(i)))  age_d[i] = '0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wptr_q <= '0;
      rptr_q <= '0;
      cnt_q  <= '0;
    end else begin
      wptr_q <= wptr_d;
      rptr_q <= rptr_d;
      cnt_q  <= cnt_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < DEPTH; i++) age_q[i] <= '0;
    end else begin
      for (int i = 0; i < DEPTH; i++) age_q[i] <= age_d[i];
    end
  end

  // Payload: no reset, written only under its write enable
  always_ff @(posedge clk) begin
    for (int i = 0; i < DEPTH; i++) begin
      if (we0 && (wptr_q == PTR_W'(i)))     mem_q[i] <= wd0;
      else if (we1 && (wptr1 == PTR_W'(i))) mem_q[i] <= wd1;
    end
  end

  assign head_d   = mem_q[rptr_q];
  assign head_age = age_q[rptr_q];
  assign count    = cnt_q;

endmodule

// File: rtl/ppq_issue.sv
// Per-cycle decision: expire the head, issue it, bypass an arrival, and
// compact the surviving arrivals into ordered write ports.
module ppq_issue import ppq_pkg::*; #(
  parameter int ENT_W     = 42,
  parameter int DEPTH     = 32,
  parameter int AGE_LIMIT = 4,
  localparam int CNT_W    = $clog2(DEPTH + 1),
  localparam int AGE_W    = $clog2(AGE_LIMIT + 1)
) (
  input  logic             lane_idle,
  input  logic             in_v0,
  input  logic [ENT_W-1:0] in_d0,
  input  logic             in_v1,
  input  logic [ENT_W-1:0] in_d1,
  input  logic [CNT_W-1:0] q_count,
  input  logic [ENT_W-1:0] head_d,
  input  logic [AGE_W-1:0] head_age,
  output logic             probe_valid,
  output logic [ENT_W-1:0] probe_d,
  output logic             pop,
  output logic             drop_pulse,
  output logic             we0,
  output logic [ENT_W-1:0] wd0,
  output logic             we1,
  output logic [ENT_W-1:0] wd1
);

  ppq_act_e         act;
  logic             nonempty, expired, keep0, keep1;
  logic [CNT_W-1:0] free_slots;

  assign nonempty   = (q_count != '0);
  assign expired    = nonempty && (head_age >= AGE_W'(AGE_LIMIT));
  assign free_slots = CNT_W'(DEPTH) - q_count;

  // Expiry has priority over any issue
  always_comb begin
    act = ACT_NONE;
    if (expired)                                      act = ACT_EXPIRE;
    else if (nonempty && lane_idle)                   act = ACT_HEAD;
    else if (!nonempty && lane_idle && (in_v0 || in_v1)) act = ACT_BYPASS;
  end

  assign probe_valid = (act == ACT_HEAD) || (act == ACT_BYPASS);
  assign probe_d     = (act == ACT_HEAD) ? head_d : (in_v0 ? in_d0 : in_d1);
  assign pop         = (act == ACT_HEAD) || (act == ACT_EXPIRE);
  assign drop_pulse  = (act == ACT_EXPIRE);

  // Arrivals not taken by the bypass, still in program order
  assign keep0 = in_v0 && (act != ACT_BYPASS);
  assign keep1 = in_v1 && !((act == ACT_BYPASS) && !in_v0);

  always_comb begin
    wd0 = keep0 ? in_d0 : in_d1;
    wd1 = in_d1;
    we0 = (keep0 || keep1) && (free_slots != '0);
    we1 = keep0 && keep1 && (free_slots >= CNT_W'(2));
  end

endmodule

// File: rtl/ppq_resp.sv
// Tracks the single probe in flight and routes its response; counts drops.
module ppq_resp #(
  parameter int ADDR_W = 32,
  parameter int TAG_W  = 6,
  parameter int DATA_W = 64,
  parameter int DROP_W = 16,
  parameter bit PF_EN  = 1'b1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              probe_valid,
  input  logic [ADDR_W-1:0] probe_addr,
  input  logic [TAG_W-1:0]  probe_tag,
  input  logic              drop_pulse,
  input  logic              rsp_valid,
  input  logic              rsp_hit,
  input  logic [DATA_W-1:0] rsp_data,
  output logic              vpe_valid,
  output logic [TAG_W-1:0]  vpe_tag,
  output logic [DATA_W-1:0] vpe_data,
  output logic              pf_valid,
  output logic [ADDR_W-1:0] pf_addr,
  output logic [DROP_W-1:0] drop_count
);

  logic              fly_v_q, fly_v_d;
  logic [ADDR_W-1:0] fly_addr_q;
  logic [TAG_W-1:0]  fly_tag_q;
  logic [DROP_W-1:0] drop_q, drop_d;
  logic              fly_ld, drop_en, rsp_live;

  assign fly_ld  = probe_valid;
  assign drop_en = drop_pulse;

  always_comb begin
    fly_v_d = probe_valid;
    drop_d  = drop_q + DROP_W'(1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      fly_v_q <= 1'b0;
      drop_q  <= '0;
    end else begin
      fly_v_q <= fly_v_d;
      if (drop_en) drop_q <= drop_d;
    end
  end

  always_ff @(posedge clk) begin
    if (fly_ld) begin
      fly_addr_q <= probe_addr;
      fly_tag_q  <= probe_tag;
    end
  end

  assign rsp_live   = rsp_valid && fly_v_q;
  assign vpe_valid  = rsp_live && rsp_hit;
  assign vpe_tag    = fly_tag_q;
  assign vpe_data   = rsp_data;
  assign pf_addr    = fly_addr_q;
  assign drop_count = drop_q;

  generate
    if (PF_EN) begin : g_pf_on
      assign pf_valid = rsp_live && !rsp_hit;
    end else begin : g_pf_off
      assign pf_valid = 1'b0;
    end
  endgenerate

endmodule

// File: rtl/pred_probe_queue.sv
module pred_probe_queue #(
  parameter int ADDR_W    = 32,
  parameter int SIZE_W    = 2,
  parameter int WAY_W     = 2,
  parameter int TAG_W     = 6,
  parameter int DATA_W    = 64,
  parameter int DEPTH     = 32,
  parameter int AGE_LIMIT = 4,
  parameter int DROP_W    = 16,
  parameter bit PF_EN     = 1'b1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              in_v0,
  input  logic [ADDR_W-1:0] in_addr0,
  input  logic [SIZE_W-1:0] in_size0,
  input  logic [WAY_W-1:0]  in_way0,
  input  logic [TAG_W-1:0]  in_tag0,
  input  logic              in_v1,
  input  logic [ADDR_W-1:0] in_addr1,
  input  logic [SIZE_W-1:0] in_size1,
  input  logic [WAY_W-1:0]  in_way1,
  input  logic [TAG_W-1:0]  in_tag1,
  input  logic              lane_idle,
  output logic              probe_valid,
  output logic [ADDR_W-1:0] probe_addr,
  output logic [SIZE_W-1:0] probe_size,
  output logic [WAY_W-1:0]  probe_way,
  output logic [TAG_W-1:0]  probe_tag,
  input  logic              rsp_valid,
  input  logic              rsp_hit,
  input  logic [DATA_W-1:0] rsp_data,
  output logic              vpe_valid,
  output logic [TAG_W-1:0]  vpe_tag,
  output logic [DATA_W-1:0] vpe_data,
  output logic              pf_valid,
  output logic [ADDR_W-1:0] pf_addr,
  output logic [DROP_W-1:0] drop_count
);

  localparam int ENT_W = TAG_W + WAY_W + SIZE_W + ADDR_W;
  localparam int CNT_W = $clog2(DEPTH + 1);
  localparam int AGE_W = $clog2(AGE_LIMIT + 1);

  logic [ENT_W-1:0] ent0, ent1, head_d, probe_d, wd0, wd1;
  logic [AGE_W-1:0] head_age;
  logic [CNT_W-1:0] q_count;
  logic             we0, we1, pop, drop_pulse;

  // Entry layout: {tag, way, size, addr}
  assign ent0 = {in_tag0, in_way0, in_size0, in_addr0};
  assign ent1 = {in_tag1, in_way1, in_size1, in_addr1};

  ppq_store #(.ENT_W(ENT_W), .DEPTH(DEPTH), .AGE_LIMIT(AGE_LIMIT)) u_store (
    .clk(clk), .rst_n(rst_n),
    .we0(we0), .wd0(wd0), .we1(we1), .wd1(wd1), .pop(pop),
    .head_d(head_d), .head_age(head_age), .count(q_count)
  );

  ppq_issue #(.ENT_W(ENT_W), .DEPTH(DEPTH), .AGE_LIMIT(AGE_LIMIT)) u_issue (
    .lane_idle(lane_idle),
    .in_v0(in_v0), .in_d0(ent0), .in_v1(in_v1), .in_d1(ent1),
    .q_count(q_count), .head_d(head_d), .head_age(head_age),
    .probe_valid(probe_valid), .probe_d(probe_d), .pop(pop), .drop_pulse(drop_pulse),
    .we0(we0), .wd0(wd0), .we1(we1), .wd1(wd1)
  );

  assign {probe_tag, probe_way, probe_size, probe_addr} = probe_d;

  ppq_resp #(.ADDR_W(ADDR_W), .TAG_W(TAG_W), .DATA_W(DATA_W),
             .DROP_W(DROP_W), .PF_EN(PF_EN)) u_resp (
    .clk(clk), .rst_n(rst_n),
    .probe_valid(probe_valid), .probe_addr(probe_addr), .probe_tag(probe_tag),
    .drop_pulse(drop_pulse),
    .rsp_valid(rsp_valid), .rsp_hit(rsp_hit), .rsp_data(rsp_data),
    .vpe_valid(vpe_valid), .vpe_tag(vpe_tag), .vpe_data(vpe_data),
    .pf_valid(pf_valid), .pf_addr(pf_addr), .drop_count(drop_count)
  );

endmodule

// File: rtl/ppq_checker.sv
module ppq_checker #(
  parameter int DEPTH  = 32,
  parameter int DROP_W = 16,
  localparam int CNT_W = $clog2(DEPTH + 1)
) (
  input logic              clk,
  input logic              rst_n,
  input logic              lane_idle,
  input logic              in_v0,
  input logic              in_v1,
  input logic              probe_valid,
  input logic              rsp_valid,
  input logic              vpe_valid,
  input logic              pf_valid,
  input logic [DROP_W-1:0] drop_count,
  input logic [CNT_W-1:0]  q_count
);

  assert_probe_only_idle_R3: assert property (@(posedge clk) disable iff (!rst_n)
    probe_valid |-> lane_idle);

  assert_bypass_has_source_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (probe_valid && (q_count == '0)) |-> (in_v0 || in_v1));

  assert_drop_single_step_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (drop_count == $past(drop_count)) || (drop_count == $past(drop_count) + DROP_W'(1)));

  assert_no_overflow_R6: assert property (@(posedge clk) disable iff (!rst_n)
    q_count <= CNT_W'(DEPTH));

  assert_value_follows_probe_R7: assert property (@(posedge clk) disable iff (!rst_n)
    vpe_valid |-> ($past(probe_valid) && rsp_valid));

  assert_hit_miss_exclusive_R8: assert property (@(posedge clk) disable iff (!rst_n)
    !(vpe_valid && pf_valid));

  assert_stray_rsp_ignored_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && !$past(probe_valid)) |-> (!vpe_valid && !pf_valid));

endmodule

bind pred_probe_queue ppq_checker #(.DEPTH(DEPTH), .DROP_W(DROP_W)) u_ppq_checker (
  .clk(clk), .rst_n(rst_n), .lane_idle(lane_idle), .in_v0(in_v0), .in_v1(in_v1),
  .probe_valid(probe_valid), .rsp_valid(rsp_valid), .vpe_valid(vpe_valid),
  .pf_valid(pf_valid), .drop_count(drop_count), .q_count(q_count)
);

// File: tb/pred_probe_queue_bench.sv
module pred_probe_queue_bench;
  localparam int DEPTH = 32;
  localparam int AGE_LIMIT = 4;

  logic clk = 1'b0;
  always #4 clk = ~clk;  // 125 MHz

  logic        rst_n;
  logic        in_v0, in_v1, lane_idle;
  logic [31:0] in_addr0, in_addr1;
  logic [1:0]  in_size0, in_size1, in_way0, in_way1;
  logic [5:0]  in_tag0, in_tag1;
  logic        probe_valid;
  logic [31:0] probe_addr;
  logic [1:0]  probe_size, probe_way;
  logic [5:0]  probe_tag;
  logic        rsp_valid, rsp_hit;
  logic [63:0] rsp_data;
  logic        vpe_valid, pf_valid;
  logic [5:0]  vpe_tag;
  logic [63:0] vpe_data;
  logic [31:0] pf_addr;
  logic [15:0] drop_count;

  pred_probe_queue u_pred_probe_queue (
    .clk(clk), .rst_n(rst_n),
    .in_v0(in_v0), .in_addr0(in_addr0), .in_size0(in_size0), .in_way0(in_way0), .in_tag0(in_tag0),
    .in_v1(in_v1), .in_addr1(in_addr1), .in_size1(in_size1), .in_way1(in_way1), .in_tag1(in_tag1),
    .lane_idle(lane_idle),
    .probe_valid(probe_valid), .probe_addr(probe_addr), .probe_size(probe_size),
    .probe_way(probe_way), .probe_tag(probe_tag),
    .rsp_valid(rsp_valid), .rsp_hit(rsp_hit), .rsp_data(rsp_data),
    .vpe_valid(vpe_valid), .vpe_tag(vpe_tag), .vpe_data(vpe_data),
    .pf_valid(pf_valid), .pf_addr(pf_addr), .drop_count(drop_count)
  );

  typedef struct {
    logic [31:0] addr;
    logic [1:0]  size;
    logic [1:0]  way;
    logic [5:0]  tag;
    int          age;
  } ent_t;

  ent_t        mq[$];
  bit          m_fly;
  logic [5:0]  m_fly_tag;
  logic [31:0] m_fly_addr;
  int          m_drops;
  bit          pend_rsp;
  string       drop_req = "R5";
  int          checks = 0;
  int          errors = 0;
  bit          finished = 1'b0;
  int          seq = 0;

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  task automatic model_step();
    ent_t pr;
    ent_t arr[$];
    bit pv, expired, nonempty, ev, ep;
    int cnt0, free_n;
    string lbl, rl;
    pv = 1'b0;
    cnt0 = mq.size();
    nonempty = (cnt0 != 0);
    expired = nonempty && (mq[0].age >= AGE_LIMIT);
    lbl = "R2";
    if (expired) begin
      lbl = "R5";
    end else if (nonempty && lane_idle) begin
      pv = 1'b1; pr = mq[0];
    end else if (!nonempty && lane_idle && (in_v0 || in_v1)) begin
      pv = 1'b1; lbl = "R4";
      if (in_v0) pr = '{in_addr0, in_size0, in_way0, in_tag0, 0};
      else       pr = '{in_addr1, in_size1, in_way1, in_tag1, 0};
    end
    if (!lane_idle) lbl = "R3";

    // Probe port
    chk(probe_valid === pv, lbl, "probe_valid", 64'(probe_valid), 64'(pv));
    if (pv) begin
      chk(probe_addr === pr.addr && probe_tag === pr.tag, lbl, "probe tag/addr",
          {26'd0, probe_tag, probe_addr}, {26'd0, pr.tag, pr.addr});
      chk(probe_size === pr.size && probe_way === pr.way, "R10", "probe size/way",
          64'({probe_size, probe_way}), 64'({pr.size, pr.way}));
    end

    // Response routing
    ev = rsp_valid && rsp_hit && m_fly;
    ep = rsp_valid && !rsp_hit && m_fly;
    rl = (rsp_valid && !m_fly) ? "R9" : "R7";
    chk(vpe_valid === ev, rl, "vpe_valid", 64'(vpe_valid), 64'(ev));
    if (ev) chk(vpe_tag === m_fly_tag && vpe_data === rsp_data, "R7", "vpe tag/data",
                vpe_data ^ 64'(vpe_tag), rsp_data ^ 64'(m_fly_tag));
    rl = (rsp_valid && !m_fly) ? "R9" : "R8";
    chk(pf_valid === ep, rl, "pf_valid", 64'(pf_valid), 64'(ep));
    if (ep) chk(pf_addr === m_fly_addr, "R8", "pf_addr", 64'(pf_addr), 64'(m_fly_addr));

    chk(drop_count === 16'(m_drops), drop_req, "drop_count", 64'(drop_count), 64'(m_drops));

    // Advance the model
    if (expired) begin
      void'(mq.pop_front());
      m_drops++;
    end else if (pv && nonempty) begin
      void'(mq.pop_front());
    end
    if (in_v0 && !(pv && !nonempty))
      arr.push_back('{in_addr0, in_size0, in_way0, in_tag0, 0});
    if (in_v1 && !(pv && !nonempty && !in_v0))
      arr.push_back('{in_addr1, in_size1, in_way1, in_tag1, 0});
    foreach (mq[i]) mq[i].age++;
    free_n = DEPTH - cnt0;
    foreach (arr[i]) if (i < free_n) mq.push_back(arr[i]);  // R6 excess discarded
    m_fly = pv;
    if (pv) begin m_fly_tag = pr.tag; m_fly_addr = pr.addr; end
    pend_rsp = pv;
  endtask

  task automatic cycle(input bit v0, input bit v1, input bit idle, input bit stray);
    in_v0 = v0; in_v1 = v1; lane_idle = idle;
    in_addr0 = $urandom; in_size0 = 2'($urandom); in_way0 = 2'($urandom);
    in_tag0 = 6'(seq); seq++;
    in_addr1 = $urandom; in_size1 = 2'($urandom); in_way1 = 2'($urandom);
    in_tag1 = 6'(seq); seq++;
    rsp_valid = pend_rsp | stray;
    rsp_hit = 1'($urandom);
    rsp_data = {$urandom, $urandom};
    @(negedge clk);
    model_step();
    @(posedge clk);
    #1;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      errors++;
      checks++;
      $display("FAIL watchdog expired");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0;
    in_v0 = 0; in_v1 = 0; lane_idle = 0; rsp_valid = 0; rsp_hit = 0; rsp_data = '0;
    in_addr0 = '0; in_addr1 = '0; in_size0 = '0; in_size1 = '0;
    in_way0 = '0; in_way1 = '0; in_tag0 = '0; in_tag1 = '0;
    m_fly = 0; m_drops = 0; pend_rsp = 0; m_fly_tag = '0; m_fly_addr = '0;
    repeat (3) begin
      @(negedge clk);
      // R1: quiet outputs during reset
      chk(probe_valid === 1'b0 && vpe_valid === 1'b0 && pf_valid === 1'b0, "R1",
          "valids in reset", 64'({probe_valid, vpe_valid, pf_valid}), 64'd0);
      chk(drop_count === 16'd0, "R1", "drop_count in reset", 64'(drop_count), 64'd0);
    end
    @(posedge clk); #1;
    rst_n = 1'b1;
    cycle(0, 0, 1, 0);                 // R1 first cycle after reset

    // R2: stored then issued in order
    cycle(1, 1, 0, 0);
    cycle(0, 0, 1, 0);
    cycle(0, 0, 1, 0);
    // R4: bypass of slot 0, slot 1 stored; then slot 1 alone bypasses
    cycle(1, 1, 1, 0);
    cycle(0, 0, 1, 0);
    cycle(0, 1, 1, 0);
    cycle(0, 0, 0, 0);
    // R5 boundary: probed at the last allowed cycle
    cycle(1, 0, 0, 0);
    repeat (3) cycle(0, 0, 0, 0);
    cycle(0, 0, 1, 0);
    // R5: one cycle later it has expired; expiry beats a free lane and arrivals
    cycle(1, 0, 0, 0);
    repeat (4) cycle(0, 0, 0, 0);
    cycle(1, 1, 1, 0);
    repeat (8) cycle(0, 0, 1, 0);
    // R9: stray response with no probe in flight
    cycle(0, 0, 0, 1);
    cycle(0, 0, 0, 1);
    // R6: fill under a busy lane until arrivals are discarded
    drop_req = "R6";
    repeat (60) cycle(1, 1, 0, 0);
    drop_req = "R5";
    repeat (50) cycle(0, 0, 1, 0);
    // Mixed traffic, including R3 busy stretches and R7/R8 responses
    for (int k = 0; k < 6000; k++) begin
      int idle_pct;
      idle_pct = ((k / 500) % 3 == 0) ? 20 : (((k / 500) % 3 == 1) ? 60 : 90);
      cycle(1'($urandom), 1'($urandom), (($urandom % 100) < idle_pct), (($urandom % 8) == 0));
    end
    repeat (10) cycle(0, 0, 1, 0);

    finished = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule